// File: doc/BRIEF.md
# Half-Cycle Windowed Energy Integrator

This block sums a stream of per-sample power values over a window made of a whole number of mains half-cycles. The window edges come from a zero-crossing strobe supplied from outside. Software sets the window length in half-cycles, an 8-bit scale divider, and an input selector through a small register write port.

The selector chooses either an apparent-power sample or an RMS-current sample as the quantity to integrate. Nothing else in the datapath changes with the selector. At each window end the wide running total is divided, clamped to 24 bits and held in the result register. A sticky completion flag is also set, and it drives an interrupt line when interrupts are enabled.

Reprogramming the window length clears the result and the running total. The block then waits for the next zero crossing before it opens a window, so the first completion after a reprogram is a full, valid measurement.

The sample input is a valid/ready stream whose ready output is held high. The block never applies back-pressure: every cycle with `s_valid` high is consumed in that cycle. While no window is open, such samples are discarded.

Top module: `lcyc_energy_acc`

## Requirements
- R1: After reset, `energy` is 0, `cycle_done` is 0, `irq` is 0 and `s_ready` is 1. The window length is 0, the divider is 0, the selector picks apparent power, and interrupts are disabled.
- R2: A window opens on a zero-crossing cycle and closes on the N-th zero-crossing cycle after that, where N is the programmed length (1 to 65535). The window sums the accepted samples from its opening cycle up to and including the cycle before its closing crossing. The closing crossing opens the next window at once, and the sample taken in that cycle belongs to the new window.
- R3: A write to address 0 loads the 16-bit window length from `cfg_wdata`. In the cycle after the write, `energy` and the running total are 0. Samples are then ignored until the next zero crossing, which opens a window without closing one. A write takes priority over a zero crossing in the same cycle.
- R4: At a window end, `energy` takes floor(total / divider) on the clock edge that ends the window. At all other times it holds its value, except when cleared under R3.
- R5: A write to address 1 loads the divider from `cfg_wdata[7:0]`. A divider of 0 acts as 1.
- R6: A quotient above 0xFFFFFF is clamped to 0xFFFFFF.
- R7: Each window end sets `cycle_done` on the same clock edge, and the flag then stays set. Writing address 3 with `cfg_wdata[0]`=1 clears it. If a window ends in the same cycle as the clear, the flag stays set.
- R8: A write to address 2 sets the interrupt enable from `cfg_wdata[1]`. `irq` is high exactly when `cycle_done` and the enable are both set.
- R9: `cfg_wdata[0]` of an address 2 write selects the quantity to integrate: 1 picks `s_irms`, 0 picks `s_va`. The new selection applies from the next cycle.
- R10: While the window length is 0, zero crossings are ignored. No window opens, no completion occurs, and `energy` and `cycle_done` do not change.
- R11: `s_ready` is always 1. A sample is added only when `s_valid` is high and a window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, always 1 |
| s_va | input | 24 | Apparent-power sample, unsigned |
| s_irms | input | 24 | RMS-current sample, unsigned |
| zc_pulse | input | 1 | Zero-crossing strobe, one cycle per half-cycle boundary |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address: 0 length, 1 divider, 2 control, 3 status clear |
| cfg_wdata | input | 16 | Register write data |
| energy | output | 24 | Latched, divided window result |
| cycle_done | output | 1 | Sticky window-complete flag |
| irq | output | 1 | Interrupt: flag gated by enable |

## Verification
Three pairs of events can fall in the same cycle:
- A window end and a write that clears the status flag.
- A reprogram of the window length and a zero crossing.
- A closing crossing and a valid sample, where the sample must go to the next window.

Directed steps force each pair with a window length of 1, so every crossing closes a window. Random steps then drop writes, crossings and samples at arbitrary cycles. After every clock edge, a bench reference built from the requirements is compared against `energy`, `cycle_done` and `irq`. The comparison decides whether the set-over-clear and write-over-crossing priorities held.

// File: rtl/lcyc_pkg.sv
package lcyc_pkg;
  typedef enum logic [1:0] {
    REG_HCNT = 2'd0,
    REG_DIV  = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam int CTRL_SEL_BIT = 0;
  localparam int CTRL_IEN_BIT = 1;
  localparam int STAT_CLR_BIT = 0;
endpackage

// File: rtl/lcyc_hc_counter.sv
module lcyc_hc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             zc,
  input  logic [CNT_W-1:0] target,
  output logic             armed,
  output logic             win_start,
  output logic             win_end
);
  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W:0]   cnt_inc;
  logic             zc_live;

  assign cnt_inc   = {1'b0, cnt_r} + 1'b1;
  assign zc_live   = zc && (target != '0) && !restart;
  assign win_end   = zc_live && armed && (cnt_inc == {1'b0, target});
  assign win_start = zc_live && (!armed || win_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt_r <= '0;
    end else if (restart) begin
      armed <= 1'b0;
      cnt_r <= '0;
    end else if (win_start) begin
      armed <= 1'b1;
      cnt_r <= '0;
    end else if (zc_live) begin
      cnt_r <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/lcyc_accum.sv
module lcyc_accum #(
  parameter int SAMPLE_W = 24,
  parameter int ACC_W    = 49,
  parameter int RES_W    = 24,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                armed,
  input  logic                win_start,
  input  logic                win_end,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [DIV_W-1:0]    divisor,
  output logic [RES_W-1:0]    result
);
  localparam logic [RES_W-1:0] RES_MAX = {RES_W{1'b1}};

  logic [ACC_W-1:0] acc_r;
  logic [ACC_W-1:0] samp_x;
  logic [DIV_W-1:0] div_eff;
  logic [ACC_W-1:0] quot;
  logic [RES_W-1:0] clamped;

  assign samp_x  = ACC_W'(sample);
  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign quot    = acc_r / ACC_W'(div_eff);
  assign clamped = (|quot[ACC_W-1:RES_W]) ? RES_MAX : quot[RES_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r <= '0;
    end else if (restart) begin
      acc_r <= '0;
    end else if (win_start) begin
      acc_r <= take ? samp_x : '0;
    end else if (armed && take) begin
      acc_r <= acc_r + samp_x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (restart) begin
      result <= '0;
    end else if (win_end) begin
      result <= clamped;
    end
  end
endmodule

// File: rtl/lcyc_status.sv
module lcyc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_evt) begin
      flag <= 1'b1;
    end else if (clr_req) begin
      flag <= 1'b0;
    end
  end

  assign irq = flag & irq_en;
endmodule

// File: rtl/lcyc_energy_acc.sv
module lcyc_energy_acc
  import lcyc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 16,
  parameter int ACC_W    = 49,
  parameter int RES_W    = 24,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_va,
  input  logic [SAMPLE_W-1:0] s_irms,
  input  logic                zc_pulse,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [CNT_W-1:0]    cfg_wdata,
  output logic [RES_W-1:0]    energy,
  output logic                cycle_done,
  output logic                irq
);
  logic [CNT_W-1:0]    hc_target;
  logic [DIV_W-1:0]    div_r;
  logic                sel_irms;
  logic                irq_en;
  logic                wr_hcnt;
  logic                wr_clr;
  logic                armed;
  logic                win_start;
  logic                win_end;
  logic                take;
  logic [SAMPLE_W-1:0] sample;

  assign s_ready = 1'b1;
  assign take    = s_valid & s_ready;
  assign sample  = sel_irms ? s_irms : s_va;
  assign wr_hcnt = cfg_we && (cfg_addr == REG_HCNT);
  assign wr_clr  = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[STAT_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_target <= '0;
      div_r     <= '0;
      sel_irms  <= 1'b0;
      irq_en    <= 1'b0;
    end else if (cfg_we) begin
      case (reg_addr_e'(cfg_addr))
        REG_HCNT: hc_target <= cfg_wdata;
        REG_DIV:  div_r     <= cfg_wdata[DIV_W-1:0];
        REG_CTRL: begin
          sel_irms <= cfg_wdata[CTRL_SEL_BIT];
          irq_en   <= cfg_wdata[CTRL_IEN_BIT];
        end
        default: ;
      endcase
    end
  end

  lcyc_hc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (wr_hcnt),
    .zc        (zc_pulse),
    .target    (hc_target),
    .armed     (armed),
    .win_start (win_start),
    .win_end   (win_end)
  );

  lcyc_accum #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .RES_W    (RES_W),
    .DIV_W    (DIV_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (wr_hcnt),
    .armed     (armed),
    .win_start (win_start),
    .win_end   (win_end),
    .take      (take),
    .sample    (sample),
    .divisor   (div_r),
    .result    (energy)
  );

  lcyc_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (win_end),
    .clr_req (wr_clr),
    .irq_en  (irq_en),
    .flag    (cycle_done),
    .irq     (irq)
  );
endmodule

// File: rtl/lcyc_energy_acc_chk.sv
module lcyc_energy_acc_chk #(
  parameter int CNT_W = 16,
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [CNT_W-1:0] cfg_wdata,
  input logic [RES_W-1:0] energy,
  input logic             cycle_done,
  input logic             irq,
  input logic             irq_en,
  input logic [CNT_W-1:0] hc_target,
  input logic             armed,
  input logic             win_end
);
  // R3
  count_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd0) |=> (energy == '0 && !armed));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !(cfg_we && cfg_addr == 2'd0)) |=> $stable(energy));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> cycle_done);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && !(cfg_we && cfg_addr == 2'd3 && cfg_wdata[0])) |=> cycle_done);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R10
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_target == '0) |-> !win_end);
endmodule

bind lcyc_energy_acc lcyc_energy_acc_chk #(.CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .energy     (energy),
  .cycle_done (cycle_done),
  .irq        (irq),
  .irq_en     (irq_en),
  .hc_target  (hc_target),
  .armed      (armed),
  .win_end    (win_end)
);

// File: tb/sim_lcyc_energy_acc.sv
module sim_lcyc_energy_acc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_va = '0;
  logic [23:0] s_irms = '0;
  logic        zc_pulse = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [23:0] energy;
  logic        cycle_done;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference state built from the requirements
  logic [15:0] m_len = '0;
  logic [7:0]  m_div = '0;
  logic        m_sel = 1'b0;
  logic        m_ien = 1'b0;
  logic        m_open = 1'b0;
  int          m_seen = 0;
  logic [48:0] m_sum = '0;
  logic [23:0] m_res = '0;
  logic        m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcyc_energy_acc u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_va(s_va), .s_irms(s_irms), .zc_pulse(zc_pulse),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .energy(energy), .cycle_done(cycle_done), .irq(irq)
  );

  function automatic logic [23:0] scaled(input logic [48:0] tot, input logic [7:0] dv);
    logic [48:0] q;
    q = tot / 49'((dv == 8'd0) ? 8'd1 : dv);
    return (q > 49'h0FFFFFF) ? 24'hFFFFFF : q[23:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d,
                      input logic zc, input logic v, input logic [23:0] va,
                      input logic [23:0] ir);
    logic reprog, closing, opening;
    logic [23:0] smp;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    zc_pulse = zc; s_valid = v; s_va = va; s_irms = ir;
    reprog  = we && a == 2'd0;
    closing = zc && !reprog && m_len != 0 && m_open && (m_seen + 1 == int'(m_len));
    opening = zc && !reprog && m_len != 0 && (!m_open || closing);
    smp = m_sel ? ir : va;
    @(posedge clk);
    if (closing) begin m_res = scaled(m_sum, m_div); m_flag = 1'b1; end
    else if (we && a == 2'd3 && d[0]) m_flag = 1'b0;
    if (reprog) begin
      m_len = d; m_open = 1'b0; m_seen = 0; m_sum = '0; m_res = '0;
    end else if (opening) begin
      m_open = 1'b1; m_seen = 0; m_sum = v ? 49'(smp) : '0;
    end else begin
      if (zc && m_len != 0) m_seen++;
      if (m_open && v) m_sum = m_sum + 49'(smp);
    end
    if (we && a == 2'd1) m_div = d[7:0];
    if (we && a == 2'd2) begin m_sel = d[0]; m_ien = d[1]; end
    #(CLK_PERIOD/4);
    check("R4 energy", 32'(energy), 32'(m_res));
    check("R7 cycle_done", 32'(cycle_done), 32'(m_flag));
    check("R8 irq", 32'(irq), 32'(m_flag & m_ien));
    @(negedge clk);
    cfg_we = 1'b0; zc_pulse = 1'b0; s_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] held;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 energy", 32'(energy), 0);
    check("R1 cycle_done", 32'(cycle_done), 0);
    check("R1 irq", 32'(irq), 0);
    check("R11 s_ready", 32'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5: length 2, divider 0, irq on
    wr(2'd0, 16'd2); wr(2'd1, 16'd0); wr(2'd2, 16'h0002);
    step(0, 0, 0, 0, 1, 24'd999, 0);             // R3: no window open yet
    step(0, 0, 0, 1, 1, 24'd10, 0);
    step(0, 0, 0, 0, 1, 24'd20, 0);
    step(0, 0, 0, 0, 1, 24'd30, 0);
    step(0, 0, 0, 1, 1, 24'd40, 0);
    step(0, 0, 0, 1, 1, 24'd5, 0);               // closes, 5 goes to next window
    check("R2 sum", 32'(energy), 100);
    check("R7 flag set", 32'(cycle_done), 1);
    check("R8 irq", 32'(irq), 1);
    held = energy;
    step(0, 0, 0, 0, 1, 24'd77, 0);
    check("R4 hold", 32'(energy), 32'(held));
    wr(2'd3, 16'h0001);
    check("R7 cleared", 32'(cycle_done), 0);

    // R10 R3: zero length ignores crossings and clears result
    wr(2'd0, 16'd0);
    check("R3 cleared", 32'(energy), 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, 24'd9, 0);
    check("R10 no completion", 32'(cycle_done), 0);
    check("R10 energy", 32'(energy), 0);

    // R6 saturation
    wr(2'd0, 16'd1); wr(2'd1, 16'd1);
    step(0, 0, 0, 1, 1, 24'hFFFFFF, 0);
    step(0, 0, 0, 0, 1, 24'hFFFFFF, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    check("R6 clamp", 32'(energy), 32'h00FFFFFF);

    // R9 current input, R5 divider 3
    wr(2'd1, 16'd3); wr(2'd2, 16'h0001);
    step(0, 0, 0, 1, 1, 24'd1000, 24'd7);
    step(0, 0, 0, 0, 1, 24'd1000, 24'd8);
    step(0, 0, 0, 1, 0, 0, 0);
    check("R9 irms select", 32'(energy), 5);

    // R7 set wins over clear in same cycle
    step(0, 0, 0, 0, 1, 0, 24'd30);
    step(1, 2'd3, 16'h0001, 1, 0, 0, 0);
    check("R7 set over clear", 32'(cycle_done), 1);
    check("R9 second window", 32'(energy), 10);

    // R3 write beats crossing in same cycle
    step(1, 2'd0, 16'd1, 1, 1, 0, 24'd50);
    step(0, 0, 0, 1, 1, 0, 24'd6);               // opens only
    step(0, 0, 0, 1, 0, 0, 0);                   // closes
    check("R3 first full window", 32'(energy), 2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic we;
      logic [1:0] a;
      logic [15:0] d;
      r = $urandom_range(0, 99);
      we = r < 8;
      a = 2'($urandom_range(0, 3));
      if (a == 2'd0) d = ($urandom_range(0, 9) == 0) ? 16'd0 : 16'($urandom_range(1, 4));
      else d = 16'($urandom);
      if (we && a == 2'd0 && $urandom_range(0, 2) != 0) a = 2'd3;
      step(we, a, d, $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0,
           24'($urandom), 24'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule